// File: doc/BRIEF.md
# Dual-Issue Pipeline Hazard Controller

This block decides, cycle by cycle, which instructions an in-order dual-issue core sends to its execution units. The core has a scalar unit and a vector coprocessor unit. Each cycle the front end offers the two oldest decoded instructions. Slot 0 holds the older one. Each slot carries a class, up to two source registers, an optional destination register and a taken bit for branches. Slot 0 also carries its fetch address. The controller answers with one issue enable per slot. The front end advances past every instruction that was issued or flagged illegal and offers the rest again in the next cycle.

A register scoreboard holds a countdown for every scalar and vector register whose result is not yet ready. Vector results need four cycles. Scalar loads and moves out of the coprocessor need three. Scalar arithmetic is forwarded to the next cycle. Besides these data hazards, the controller applies several structural and control rules. A store placed exactly two cycles after a load costs one cycle, and coprocessor moves count as both a load and a store. Delay slots and unaligned branch targets issue on their own. A taken branch costs one empty cycle. A branch found in a delay slot is flagged and dropped.

Top module: `dual_issue_ctrl`

## Requirements
- R1: While `rst_n` is low, `issue0`, `issue1`, `bubble` and `illegal` are all 0. After reset all counters are clear, so an independent scalar/vector pair offered in the first cycle issues together.
- R2: Classes 5 (vector compute), 6 (vector load) and 8 (move into a vector register) with an enabled destination make that register unavailable. A later instruction that reads it issues no earlier than 4 cycles after the producer. Register ids are 6 bits, and bit 5 selects the vector file.
- R3: Classes 1 (scalar load) and 3 (move from a vector register to a scalar register) make their destination unavailable. A reader issues no earlier than 3 cycles after the producer.
- R4: The result of class 0 (scalar compute) can be read in the next cycle. A slot 1 instruction that reads the destination of slot 0 never issues in the same cycle as slot 0.
- R5: If a cycle issued any of classes 1, 3, 6 or 8, an instruction of class 2, 3, 7 or 8 (the store-like classes) offered two cycles later is held for that cycle.
- R6: Slot 1 issues only when slot 0 issues. Two instructions for the same unit never issue together. Classes 5–8 go to the vector unit and all others go to the scalar unit.
- R7: A branch (class 4) in slot 1 may issue together with slot 0. A branch in slot 0 issues alone. The instruction after any issued branch is its delay slot and issues alone.
- R8: A branch offered as a delay slot drives `illegal` high for one cycle, is not issued and is consumed.
- R9: After the delay slot of a taken branch is consumed, the next cycle issues nothing and drives `bubble` high.
- R10: The first slot 0 instruction after that empty cycle is the branch target. If its address has any of bits [2:0] set, it issues alone. If the address is aligned, it may issue with slot 1.
- R11: `bubble` is high exactly when slot 0 is valid, or an empty cycle is forced, and slot 0 is neither issued nor flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_class | input | 4 | Slot 0 class code |
| s0_src_a | input | 6 | Slot 0 first source register id |
| s0_src_a_en | input | 1 | Slot 0 first source is read |
| s0_src_b | input | 6 | Slot 0 second source register id |
| s0_src_b_en | input | 1 | Slot 0 second source is read |
| s0_dst | input | 6 | Slot 0 destination register id |
| s0_dst_en | input | 1 | Slot 0 writes its destination |
| s0_taken | input | 1 | Slot 0 branch is taken |
| s0_pc | input | 32 | Slot 0 fetch address |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_class | input | 4 | Slot 1 class code |
| s1_src_a | input | 6 | Slot 1 first source register id |
| s1_src_a_en | input | 1 | Slot 1 first source is read |
| s1_src_b | input | 6 | Slot 1 second source register id |
| s1_src_b_en | input | 1 | Slot 1 second source is read |
| s1_dst | input | 6 | Slot 1 destination register id |
| s1_dst_en | input | 1 | Slot 1 writes its destination |
| s1_taken | input | 1 | Slot 1 branch is taken |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| bubble | output | 1 | Nothing issues although work or a forced gap is present |
| illegal | output | 1 | Slot 0 is a branch in a delay slot and is dropped |

## Verification
Short instruction streams are fed, each built so that exactly one rule decides the issue cycle. Dependent vector and scalar pairs are used, and each one separates the four-cycle, three-cycle and forwarded latencies by the gap between issue cycles. Store-after-load streams are run once with plain loads and stores and once with coprocessor moves on each side, which shows that moves count in both roles. Branch streams place the branch in either slot, put a branch into a delay slot, and vary target alignment. These streams separate dual issue, delay-slot single issue, the taken-branch gap and the target rule.

// File: rtl/dual_issue_pkg.sv
`timescale 1ns/1ps
// Shared class codes and class predicates for the dual-issue controller.
// Assumes a 4-bit class code produced by the decoder.
package dual_issue_pkg;
    localparam logic [3:0] CL_SCOMP  = 4'd0;
    localparam logic [3:0] CL_SLOAD  = 4'd1;
    localparam logic [3:0] CL_SSTORE = 4'd2;
    localparam logic [3:0] CL_VTOS   = 4'd3;
    localparam logic [3:0] CL_BRANCH = 4'd4;
    localparam logic [3:0] CL_VCOMP  = 4'd5;
    localparam logic [3:0] CL_VLOAD  = 4'd6;
    localparam logic [3:0] CL_VSTORE = 4'd7;
    localparam logic [3:0] CL_STOV   = 4'd8;

    // Unit selection: 1 = vector unit
    function automatic logic goes_vector(input logic [3:0] c);
        return (c == CL_VCOMP) || (c == CL_VLOAD) || (c == CL_VSTORE) || (c == CL_STOV);
    endfunction

    // Counts as a load for the load/store spacing rule
    function automatic logic load_like(input logic [3:0] c);
        return (c == CL_SLOAD) || (c == CL_VLOAD) || (c == CL_VTOS) || (c == CL_STOV);
    endfunction

    // Counts as a store for the load/store spacing rule
    function automatic logic store_like(input logic [3:0] c);
        return (c == CL_SSTORE) || (c == CL_VSTORE) || (c == CL_VTOS) || (c == CL_STOV);
    endfunction

    // Cycles from issue until a result may be consumed; 0 = forwarded
    function automatic int unsigned ready_after(input logic [3:0] c,
                                                input int unsigned vlat,
                                                input int unsigned slat);
        if ((c == CL_VCOMP) || (c == CL_VLOAD) || (c == CL_STOV)) return vlat;
        if ((c == CL_SLOAD) || (c == CL_VTOS)) return slat;
        return 0;
    endfunction
endpackage

// File: rtl/hz_scoreboard.sv
`timescale 1ns/1ps
// Register scoreboard: one down-counter per scalar and vector register.
// A counter holds the cycles left before its register may be read; zero
// means ready. Write port 1 (younger slot) wins over port 0 on the same id.
// Assumes NENT is a power of two matching the id width.
module hz_scoreboard #(
    parameter int NENT = 64,
    parameter int CW   = 2,
    parameter int NRD  = 4,
    localparam int IDW = $clog2(NENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][IDW-1:0]   rd_id,
    output logic [NRD-1:0]            rd_ready,
    input  logic [1:0]                wr_en,
    input  logic [1:0][IDW-1:0]       wr_id,
    input  logic [1:0][CW-1:0]        wr_val
);
    logic [NENT-1:0][CW-1:0] cnt_flat;

    for (genvar g = 0; g < NENT; g++) begin : g_ent
        logic [CW-1:0] ctr;
        logic hit0, hit1;
        assign hit0 = wr_en[0] && (wr_id[0] == IDW'(g));
        assign hit1 = wr_en[1] && (wr_id[1] == IDW'(g));

        // Load a new latency on issue, otherwise count down to zero
        always_ff @(posedge clk) begin
            if (!rst_n)          ctr <= '0;
            else if (hit1)       ctr <= wr_val[1];
            else if (hit0)       ctr <= wr_val[0];
            else if (ctr != '0)  ctr <= ctr - 1'b1;
        end
        assign cnt_flat[g] = ctr;

        // R2/R3: an untouched pending counter falls by exactly one per cycle
        p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit0 && !hit1 && ctr != '0) |=> (ctr == CW'($past(ctr) - 1'b1)));
    end

    // Ready lookup for every source port
    always_comb begin
        for (int r = 0; r < NRD; r++) rd_ready[r] = (cnt_flat[rd_id[r]] == '0);
    end
endmodule

// File: rtl/issue_arbiter.sv
`timescale 1ns/1ps
// Combinational pair decision: which of the two offered slots issue.
// Assumes scoreboard readiness and control state arrive from registers,
// so no path loops back from the issue outputs.
module issue_arbiter #(
    parameter int IDW = 6
) (
    input  logic           rst_n,
    input  logic           v0,
    input  logic           v1,
    input  logic [3:0]     cls0,
    input  logic [3:0]     cls1,
    input  logic           srcs_ok0,
    input  logic           srcs_ok1,
    input  logic [IDW-1:0] dst0,
    input  logic           dst0_en,
    input  logic [IDW-1:0] s1_src_a,
    input  logic           s1_src_a_en,
    input  logic [IDW-1:0] s1_src_b,
    input  logic           s1_src_b_en,
    input  logic           ld_two_ago,
    input  logic           in_delay,
    input  logic           at_target,
    input  logic           force_gap,
    input  logic           pc0_unaligned,
    output logic           issue0,
    output logic           issue1,
    output logic           illegal
);
    import dual_issue_pkg::*;

    logic pair_raw, pair_block;

    // Slot 1 reading what slot 0 writes in the same cycle
    always_comb begin
        pair_raw = dst0_en && ((s1_src_a_en && s1_src_a == dst0) ||
                               (s1_src_b_en && s1_src_b == dst0));
    end

    // Conditions that force slot 0 to issue alone
    always_comb begin
        pair_block = in_delay || (cls0 == CL_BRANCH) || (at_target && pc0_unaligned) ||
                     (goes_vector(cls0) == goes_vector(cls1));
    end

    // Final issue and illegal decisions, in order
    always_comb begin
        illegal = rst_n && v0 && in_delay && !force_gap && (cls0 == CL_BRANCH);
        issue0  = rst_n && v0 && !force_gap && !illegal && srcs_ok0 &&
                  !(ld_two_ago && store_like(cls0));
        issue1  = issue0 && v1 && !pair_block && srcs_ok1 && !pair_raw &&
                  !(ld_two_ago && store_like(cls1));
    end
endmodule

// File: rtl/branch_flow_track.sv
`timescale 1ns/1ps
// Control-flow and spacing state: load history, delay-slot tracking,
// the forced gap after a taken branch and the target marker.
// Assumes the front end advances past issued or illegal instructions only.
module branch_flow_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue0,
    input  logic       issue1,
    input  logic       illegal,
    input  logic [3:0] cls0,
    input  logic [3:0] cls1,
    input  logic       taken0,
    input  logic       taken1,
    output logic       ld_two_ago,
    output logic       in_delay,
    output logic       at_target,
    output logic       force_gap
);
    import dual_issue_pkg::*;

    logic ld_one_ago, loaded_now, br0, br1, pend_taken;

    always_comb begin
        loaded_now = (issue0 && load_like(cls0)) || (issue1 && load_like(cls1));
        br0 = issue0 && (cls0 == CL_BRANCH);
        br1 = issue1 && (cls1 == CL_BRANCH);
    end

    // Two-cycle history of load-like issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_one_ago <= 1'b0;
            ld_two_ago <= 1'b0;
        end else begin
            ld_one_ago <= loaded_now;
            ld_two_ago <= ld_one_ago;
        end
    end

    // Delay slot, pending taken branch and forced gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_delay   <= 1'b0;
            pend_taken <= 1'b0;
            force_gap  <= 1'b0;
        end else begin
            force_gap <= 1'b0;
            if (br0 || br1) begin
                in_delay   <= 1'b1;
                pend_taken <= br1 ? taken1 : taken0;
            end else if (in_delay && (issue0 || illegal)) begin
                in_delay   <= 1'b0;
                pend_taken <= 1'b0;
                force_gap  <= pend_taken;
            end
        end
    end

    // Marks slot 0 as the branch target until it issues
    always_ff @(posedge clk) begin
        if (!rst_n)                  at_target <= 1'b0;
        else if (force_gap)          at_target <= 1'b1;
        else if (at_target && issue0) at_target <= 1'b0;
    end

    p_gap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_gap |-> (!issue0 && !issue1));
    p_delay_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_delay |-> !issue1);
endmodule

// File: rtl/dual_issue_ctrl.sv
`timescale 1ns/1ps
// Issue and stall controller for a dual-issue in-order scalar + vector core.
// Slot 0 is the older instruction. Register ids carry the vector-file select
// in their top bit. Assumes the front end re-offers unconsumed instructions.
module dual_issue_ctrl #(
    parameter int NREG        = 32,
    parameter int VEC_LAT     = 4,
    parameter int SCL_LAT     = 3,
    parameter int PCW         = 32,
    parameter int ALIGN_BYTES = 8,
    localparam int IDW        = $clog2(NREG) + 1,
    localparam int MAXL       = (VEC_LAT > SCL_LAT) ? VEC_LAT : SCL_LAT,
    localparam int CW         = (MAXL > 2) ? $clog2(MAXL) : 1,
    localparam int ALSB       = $clog2(ALIGN_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s0_valid,
    input  logic [3:0]     s0_class,
    input  logic [IDW-1:0] s0_src_a,
    input  logic           s0_src_a_en,
    input  logic [IDW-1:0] s0_src_b,
    input  logic           s0_src_b_en,
    input  logic [IDW-1:0] s0_dst,
    input  logic           s0_dst_en,
    input  logic           s0_taken,
    input  logic [PCW-1:0] s0_pc,
    input  logic           s1_valid,
    input  logic [3:0]     s1_class,
    input  logic [IDW-1:0] s1_src_a,
    input  logic           s1_src_a_en,
    input  logic [IDW-1:0] s1_src_b,
    input  logic           s1_src_b_en,
    input  logic [IDW-1:0] s1_dst,
    input  logic           s1_dst_en,
    input  logic           s1_taken,
    output logic           issue0,
    output logic           issue1,
    output logic           bubble,
    output logic           illegal
);
    import dual_issue_pkg::*;

    logic [3:0][IDW-1:0] rd_id;
    logic [3:0]          rd_ready;
    logic [1:0]          wr_en;
    logic [1:0][IDW-1:0] wr_id;
    logic [1:0][CW-1:0]  wr_val;
    logic srcs_ok0, srcs_ok1, ld_two_ago, in_delay, at_target, force_gap;
    int unsigned lat0, lat1;

    // Source lookups and per-slot readiness
    always_comb begin
        rd_id    = {s1_src_b, s1_src_a, s0_src_b, s0_src_a};
        srcs_ok0 = (!s0_src_a_en || rd_ready[0]) && (!s0_src_b_en || rd_ready[1]);
        srcs_ok1 = (!s1_src_a_en || rd_ready[2]) && (!s1_src_b_en || rd_ready[3]);
    end

    // Scoreboard writes for issued producers with a non-forwarded result
    always_comb begin
        lat0      = ready_after(s0_class, VEC_LAT, SCL_LAT);
        lat1      = ready_after(s1_class, VEC_LAT, SCL_LAT);
        wr_en[0]  = issue0 && s0_dst_en && (lat0 > 0);
        wr_en[1]  = issue1 && s1_dst_en && (lat1 > 0);
        wr_id[0]  = s0_dst;
        wr_id[1]  = s1_dst;
        wr_val[0] = CW'(lat0 - 1);
        wr_val[1] = CW'(lat1 - 1);
    end

    hz_scoreboard #(.NENT(2 * NREG), .CW(CW), .NRD(4)) u_sb (
        .clk(clk), .rst_n(rst_n), .rd_id(rd_id), .rd_ready(rd_ready),
        .wr_en(wr_en), .wr_id(wr_id), .wr_val(wr_val)
    );

    issue_arbiter #(.IDW(IDW)) u_arb (
        .rst_n(rst_n), .v0(s0_valid), .v1(s1_valid), .cls0(s0_class), .cls1(s1_class),
        .srcs_ok0(srcs_ok0), .srcs_ok1(srcs_ok1), .dst0(s0_dst), .dst0_en(s0_dst_en),
        .s1_src_a(s1_src_a), .s1_src_a_en(s1_src_a_en),
        .s1_src_b(s1_src_b), .s1_src_b_en(s1_src_b_en),
        .ld_two_ago(ld_two_ago), .in_delay(in_delay), .at_target(at_target),
        .force_gap(force_gap), .pc0_unaligned(|s0_pc[ALSB-1:0]),
        .issue0(issue0), .issue1(issue1), .illegal(illegal)
    );

    branch_flow_track u_flow (
        .clk(clk), .rst_n(rst_n), .issue0(issue0), .issue1(issue1), .illegal(illegal),
        .cls0(s0_class), .cls1(s1_class), .taken0(s0_taken), .taken1(s1_taken),
        .ld_two_ago(ld_two_ago), .in_delay(in_delay), .at_target(at_target),
        .force_gap(force_gap)
    );

    // Stall indicator
    always_comb begin
        bubble = rst_n && (s0_valid || force_gap) && !issue0 && !illegal;
    end

    p_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> issue0);
    p_one_per_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && issue1) |-> (goes_vector(s0_class) != goes_vector(s1_class)));
    p_illegal_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!issue0 && !issue1));
    p_branch_then_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && s0_class == CL_BRANCH) |-> !issue1);
endmodule

// File: tb/dual_issue_ctrl_test.sv
`timescale 1ns/1ps
module dual_issue_ctrl_test;
    typedef struct {
        bit v; int cls; int sa; bit sae; int sb; bit sbe; int d; bit de; bit tk; int pc;
    } ins_t;

    logic clk = 0, rst_n = 0;
    logic s0_valid, s0_src_a_en, s0_src_b_en, s0_dst_en, s0_taken;
    logic s1_valid, s1_src_a_en, s1_src_b_en, s1_dst_en, s1_taken;
    logic [3:0] s0_class, s1_class;
    logic [5:0] s0_src_a, s0_src_b, s0_dst, s1_src_a, s1_src_b, s1_dst;
    logic [31:0] s0_pc;
    logic issue0, issue1, bubble, illegal;

    always #10 clk = ~clk;

    dual_issue_ctrl uut (.*);

    int checks = 0, errors = 0;
    ins_t prog[0:15];
    int plen, iss_cyc[0:15], ill_cnt, bub_cnt;
    bit bubm[0:63];
    // reference model state
    int cnt[0:63];
    bit m_ld1, m_ld2, m_dly, m_pend, m_gap, m_tgt;
    bit e_i0, e_i1, e_ill, e_bub;

    function automatic ins_t mk(int cls, int sa, int sb, int d, bit tk = 0, int pc = 0);
        ins_t r;
        r.v = 1; r.cls = cls; r.sa = (sa < 0) ? 0 : sa; r.sae = (sa >= 0);
        r.sb = (sb < 0) ? 0 : sb; r.sbe = (sb >= 0); r.d = (d < 0) ? 0 : d; r.de = (d >= 0);
        r.tk = tk; r.pc = pc;
        return r;
    endfunction
    function automatic ins_t none();
        ins_t r = '{default: 0};
        return r;
    endfunction
    function automatic bit vec_u(int c); return c >= 5 && c <= 8; endfunction
    function automatic bit is_ld(int c); return c == 1 || c == 3 || c == 6 || c == 8; endfunction
    function automatic bit is_st(int c); return c == 2 || c == 3 || c == 7 || c == 8; endfunction
    function automatic int lat(int c);
        if (c == 5 || c == 6 || c == 8) return 4;
        if (c == 1 || c == 3) return 3;
        return 0;
    endfunction
    function automatic bit rdy(ins_t a);
        return (!a.sae || cnt[a.sa] == 0) && (!a.sbe || cnt[a.sb] == 0);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 64; r++) cnt[r] = 0;
        {m_ld1, m_ld2, m_dly, m_pend, m_gap, m_tgt} = '0;
    endtask

    task automatic model_eval(ins_t a, ins_t b);
        bit raw;
        raw = a.v && a.de && ((b.sae && b.sa == a.d) || (b.sbe && b.sb == a.d));
        e_ill = a.v && m_dly && !m_gap && a.cls == 4;
        e_i0 = a.v && !m_gap && !e_ill && rdy(a) && !(m_ld2 && is_st(a.cls));
        e_i1 = e_i0 && b.v && vec_u(a.cls) != vec_u(b.cls) && rdy(b) && !raw && !m_dly &&
               a.cls != 4 && !(m_tgt && (a.pc % 8) != 0) && !(m_ld2 && is_st(b.cls));
        e_bub = (a.v || m_gap) && !e_i0 && !e_ill;
    endtask

    task automatic model_step(ins_t a, ins_t b);
        bit loaded, ngap;
        for (int r = 0; r < 64; r++) if (cnt[r] > 0) cnt[r]--;
        if (e_i0 && a.de && lat(a.cls) > 0) cnt[a.d] = lat(a.cls) - 1;
        if (e_i1 && b.de && lat(b.cls) > 0) cnt[b.d] = lat(b.cls) - 1;
        loaded = (e_i0 && is_ld(a.cls)) || (e_i1 && is_ld(b.cls));
        m_ld2 = m_ld1; m_ld1 = loaded;
        if (m_gap) m_tgt = 1; else if (m_tgt && e_i0) m_tgt = 0;
        ngap = 0;
        if ((e_i0 && a.cls == 4) || (e_i1 && b.cls == 4)) begin
            m_dly = 1; m_pend = (e_i1 && b.cls == 4) ? b.tk : a.tk;
        end else if (m_dly && (e_i0 || e_ill)) begin
            m_dly = 0; ngap = m_pend; m_pend = 0;
        end
        m_gap = ngap;
    endtask

    task automatic drive(ins_t a, ins_t b);
        s0_valid = a.v; s0_class = 4'(a.cls); s0_src_a = 6'(a.sa); s0_src_a_en = a.sae;
        s0_src_b = 6'(a.sb); s0_src_b_en = a.sbe; s0_dst = 6'(a.d); s0_dst_en = a.de;
        s0_taken = a.tk; s0_pc = 32'(a.pc);
        s1_valid = b.v; s1_class = 4'(b.cls); s1_src_a = 6'(b.sa); s1_src_a_en = b.sae;
        s1_src_b = 6'(b.sb); s1_src_b_en = b.sbe; s1_dst = 6'(b.d); s1_dst_en = b.de;
        s1_taken = b.tk;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        drive(mk(0, -1, -1, 1), mk(5, -1, -1, 33));
        @(negedge clk); #5;
        check("R1", {issue0, issue1, bubble, illegal}, 0, "outputs in reset");
        @(negedge clk); rst_n = 1;
        model_reset();
    endtask

    task automatic run(string tag);
        int head = 0, cyc = 0;
        ins_t a, b;
        ill_cnt = 0; bub_cnt = 0;
        for (int k = 0; k < 16; k++) iss_cyc[k] = -1;
        for (int k = 0; k < 64; k++) bubm[k] = 0;
        do_reset();
        while (head < plen && cyc < 60) begin
            a = (head < plen) ? prog[head] : none();
            b = (head + 1 < plen) ? prog[head + 1] : none();
            drive(a, b);
            #5;
            model_eval(a, b);
            check(tag, issue0, e_i0, "issue0");
            check(tag, issue1, e_i1, "issue1");
            check(tag, illegal, e_ill, "illegal");
            check("R11", bubble, e_bub, "bubble");
            if (issue0) iss_cyc[head] = cyc;
            if (issue1 && head + 1 < 16) iss_cyc[head + 1] = cyc;
            if (illegal) ill_cnt++;
            if (bubble) begin bub_cnt++; bubm[cyc] = 1; end
            model_step(a, b);
            head += (e_i0 || e_ill) + e_i1;
            cyc++;
            @(negedge clk);
        end
        drive(none(), none());
    endtask

    task automatic expect4(string tag, int c0, int c1, int c2, int c3);
        check(tag, iss_cyc[0], c0, "issue cycle of instr 0");
        check(tag, iss_cyc[1], c1, "issue cycle of instr 1");
        if (plen > 2) check(tag, iss_cyc[2], c2, "issue cycle of instr 2");
        if (plen > 3) check(tag, iss_cyc[3], c3, "issue cycle of instr 3");
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive(none(), none());
        // R1: independent pair right after reset
        plen = 2; prog[0] = mk(0, -1, -1, 1); prog[1] = mk(5, -1, -1, 33);
        run("R1"); expect4("R1", 0, 0, 0, 0);
        // R2: vector result and move into vector register, 4-cycle spacing
        plen = 4; prog[0] = mk(5, -1, -1, 35); prog[1] = mk(5, 35, -1, 36);
        prog[2] = mk(8, 1, -1, 37); prog[3] = mk(5, 37, -1, 38);
        run("R2"); expect4("R2", 0, 4, 5, 9);
        check("R11", bub_cnt, 6, "bubble cycles for vector chain");
        // R3: scalar load and move out of vector file, 3-cycle spacing
        prog[0] = mk(1, -1, -1, 2); prog[1] = mk(0, 2, -1, 20);
        prog[2] = mk(3, 36, -1, 3); prog[3] = mk(0, 3, -1, 21);
        run("R3"); expect4("R3", 0, 3, 4, 7);
        // R4: forwarded scalar result, no same-cycle pair dependence
        prog[0] = mk(0, -1, -1, 4); prog[1] = mk(0, 4, -1, 22);
        prog[2] = mk(0, -1, -1, 5); prog[3] = mk(5, 5, -1, 33);
        run("R4"); expect4("R4", 0, 1, 2, 3);
        // R5: load then store two cycles later
        prog[0] = mk(1, -1, -1, 6); prog[1] = mk(5, -1, -1, 33);
        prog[2] = mk(0, -1, -1, 7); prog[3] = mk(2, 8, -1, -1);
        run("R5"); expect4("R5", 0, 0, 1, 3);
        // R5: move into vector file acts as load
        plen = 5; prog[0] = mk(8, 1, -1, 39); prog[1] = mk(0, -1, -1, 9);
        prog[2] = mk(5, -1, -1, 40); prog[3] = mk(0, -1, -1, 10); prog[4] = mk(7, 41, -1, -1);
        run("R5"); expect4("R5", 0, 0, 1, 1);
        check("R5", iss_cyc[4], 3, "vector store after move");
        // R5: move out of vector file acts as store
        plen = 4; prog[0] = mk(1, -1, -1, 10); prog[1] = mk(5, -1, -1, 34);
        prog[2] = mk(0, -1, -1, 11); prog[3] = mk(3, 44, -1, 12);
        run("R5"); expect4("R5", 0, 0, 1, 3);
        // R6/R7: branch in slot 1 pairs, delay slot alone
        prog[0] = mk(5, -1, -1, 33); prog[1] = mk(4, -1, -1, -1);
        prog[2] = mk(0, -1, -1, 2); prog[3] = mk(5, -1, -1, 34);
        run("R7"); expect4("R7", 0, 0, 1, 2);
        // R7: branch in slot 0 alone, delay slot alone
        plen = 3; prog[0] = mk(4, -1, -1, -1); prog[1] = mk(5, -1, -1, 33);
        prog[2] = mk(0, -1, -1, 1);
        run("R7"); expect4("R7", 0, 1, 2, 0);
        // R6: two scalar ops never pair
        plen = 2; prog[0] = mk(0, -1, -1, 1); prog[1] = mk(2, 9, -1, -1);
        run("R6"); expect4("R6", 0, 1, 0, 0);
        // R8: branch in delay slot
        plen = 4; prog[0] = mk(4, -1, -1, -1); prog[1] = mk(4, -1, -1, -1);
        prog[2] = mk(0, -1, -1, 1); prog[3] = mk(5, -1, -1, 33);
        run("R8"); expect4("R8", 0, -1, 2, 2);
        check("R8", ill_cnt, 1, "illegal pulses");
        // R9/R10: taken branch, unaligned target
        prog[0] = mk(4, -1, -1, -1, 1, 0); prog[1] = mk(0, -1, -1, 1, 0, 4);
        prog[2] = mk(5, -1, -1, 33, 0, 'h104); prog[3] = mk(0, -1, -1, 2, 0, 'h108);
        run("R10"); expect4("R10", 0, 1, 3, 4);
        check("R9", bubm[2], 1, "bubble after delay slot");
        check("R9", bub_cnt, 1, "bubble count");
        // R10: aligned target may pair
        prog[2].pc = 'h100;
        run("R10"); expect4("R10", 0, 1, 3, 3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule